// File: doc/BRIEF.md
# Toggle Output with Auto-Off Timer

This block holds one on/off state for a touch-operated switch. Every confirmed touch strobe flips the state. When the state turns on, a countdown starts, and the block turns the output off by itself when that countdown runs out. A two-bit strap picks one of three preset delays: a short one, a long one, or no timeout. A multiplier strap is captured once after reset and scales every later delay by 1 or by a large factor. A polarity strap sets whether "on" drives the pin high or low.

A single override line carries pulses that the block measures. It samples the line once per acquisition tick, and a free-running prescaler produces that tick from the clock. A short pulse restarts the countdown. A long pulse forces the output off. While the line is held away from its idle level, touches are blocked and a burst-inhibit flag is raised. When the line returns to idle, a one-cycle recalibration request is issued, and the output keeps whatever state it had.

Top module: `toggle_autooff`

## Requirements
- R1: After reset the state is off. While `burst_inh_o` is low, each cycle with `touch_i` high inverts the state at that clock edge.
- R2: Each transition to on loads the full selected delay of N ticks. The output turns off at the N-th tick edge after the turn-on edge, unless a reload or a touch intervenes.
- R3: `dly_sel_i` code 0 selects the short delay when `pol_i`=0 and no timeout when `pol_i`=1. Code 1 selects no timeout when `pol_i`=0 and the short delay when `pol_i`=1. Codes 2 and 3 select the long delay for either polarity. With no timeout, only a touch or a cancel turns the state off.
- R4: `mult_sel_i` is captured in the first cycle after reset release. A captured 0 scales delays by 1 and a captured 1 scales them by MULT_HI. Later changes of `mult_sel_i` have no effect.
- R5: `pin_o` equals the state when `pol_i`=0 and the inverse of the state when `pol_i`=1.
- R6: A tick occurs at the edges where the number of edges since reset release, taken modulo CLK_PER_TICK, equals CLK_PER_TICK-1. The line `ovr_i` is sampled at each tick. It is active when it differs from the captured multiplier level. `burst_inh_o` goes high at the first active sample and low at the first inactive sample after that.
- R7: If the pulse is released after W active samples, with PULSE_SHORT_MIN ≤ W ≤ PULSE_SHORT_MAX, and the state is on, the countdown is reloaded to the full delay at the release tick. Any other W below PULSE_LONG_MIN has no effect on the output.
- R8: At the PULSE_LONG_MIN-th consecutive active sample, the state is forced off. Touches stay ignored until the line is released.
- R9: At the release tick, `recal_req_o` goes high for exactly one cycle, and the on/off state is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| touch_i | input | 1 | One-cycle confirmed-touch strobe |
| dly_sel_i | input | 2 | Preset delay strap code |
| pol_i | input | 1 | Output polarity strap, 0 = active high |
| mult_sel_i | input | 1 | Delay multiplier strap, captured after reset |
| ovr_i | input | 1 | Synchronized override line |
| pin_o | output | 1 | Polarity-adjusted output level |
| burst_inh_o | output | 1 | High while an override pulse is held |
| recal_req_o | output | 1 | One-cycle recalibration request |

## Verification
The bench builds the block with 4 clocks per tick, short and long delays of 8 and 12 ticks, the default multiplier of 24, and pulse thresholds of 2, 3 and 6 ticks. These values let it step through every polarity, delay code and multiplier combination and watch the exact expiry tick, including the 288-tick long delay at ×24, within a short run. Pulse widths from 1 to 7 ticks are swept under both multiplier levels. This covers ignored, reloading and cancelling pulses, touches blocked during a hold, and the recalibration strobe on each release.

// File: rtl/toggle_autooff_pkg.sv
package toggle_autooff_pkg;
  typedef enum logic [1:0] {
    SEL_TIED_LO  = 2'd0,
    SEL_TIED_HI  = 2'd1,
    SEL_FOLLOW   = 2'd2,
    SEL_FOLLOW_B = 2'd3
  } dly_code_e;
endpackage

// File: rtl/tao_prescaler.sv
module tao_prescaler #(
  parameter int unsigned DIV = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = (cnt_q == LAST);
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6: ticks are isolated single-cycle strobes
  p_tick_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tao_override_dec.sv
module tao_override_dec #(
  parameter int unsigned SHORT_MIN = 5,
  parameter int unsigned SHORT_MAX = 12,
  parameter int unsigned LONG_MIN  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic line_i,
  input  logic idle_lvl_i,
  output logic held_o,
  output logic cancel_o,
  output logic retrig_o,
  output logic recal_o
);
  localparam int unsigned WW = $clog2(LONG_MIN + 1);
  localparam logic [WW-1:0] W_SMIN = WW'(SHORT_MIN);
  localparam logic [WW-1:0] W_SMAX = WW'(SHORT_MAX);
  localparam logic [WW-1:0] W_LMIN = WW'(LONG_MIN);
  localparam logic [WW-1:0] W_LAST = WW'(LONG_MIN - 1);

  logic [WW-1:0] width_q, width_d;
  logic          held_q, held_d;
  logic          recal_q, recal_d;
  logic          active;

  always_comb begin
    active   = line_i ^ idle_lvl_i;
    width_d  = width_q;
    held_d   = held_q;
    recal_d  = 1'b0;
    cancel_o = 1'b0;
    retrig_o = 1'b0;
    if (tick_i) begin
      if (active) begin
        held_d   = 1'b1;
        if (width_q != W_LMIN) width_d = width_q + 1'b1;
        cancel_o = (width_q == W_LAST);
      end else if (held_q) begin
        held_d   = 1'b0;
        width_d  = '0;
        recal_d  = 1'b1;
        retrig_o = (width_q >= W_SMIN) && (width_q <= W_SMAX);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= '0;
      held_q  <= 1'b0;
      recal_q <= 1'b0;
    end else begin
      width_q <= width_d;
      held_q  <= held_d;
      recal_q <= recal_d;
    end
  end

  assign held_o  = held_q;
  assign recal_o = recal_q;

  // R9: the recalibration request lasts one cycle
  p_recal_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    recal_q |=> !recal_q);
  // R7: a reload only happens on a release, which ends the hold
  p_retrig_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retrig_o |=> (recal_q && !held_q));
endmodule

// File: rtl/tao_offtimer.sv
module tao_offtimer
  import toggle_autooff_pkg::*;
#(
  parameter int unsigned DLY_A   = 90000,
  parameter int unsigned DLY_B   = 360000,
  parameter int unsigned MULT_HI = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic       retrig_i,
  input  logic       on_i,
  input  logic [1:0] dly_sel_i,
  input  logic       pol_i,
  input  logic       mult_i,
  output logic       expire_o
);
  localparam int unsigned MAX_LOAD = ((DLY_A > DLY_B) ? DLY_A : DLY_B) * MULT_HI;
  localparam int unsigned CW = $clog2(MAX_LOAD + 1);
  localparam logic [CW-1:0] LA1 = CW'(DLY_A);
  localparam logic [CW-1:0] LAM = CW'(DLY_A * MULT_HI);
  localparam logic [CW-1:0] LB1 = CW'(DLY_B);
  localparam logic [CW-1:0] LBM = CW'(DLY_B * MULT_HI);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d, load_val;
  logic          timed_q, timed_d, sel_timed, reload, step;

  always_comb begin
    case (dly_code_e'(dly_sel_i))
      SEL_TIED_LO: begin sel_timed = !pol_i; load_val = mult_i ? LAM : LA1; end
      SEL_TIED_HI: begin sel_timed =  pol_i; load_val = mult_i ? LAM : LA1; end
      default:     begin sel_timed = 1'b1;   load_val = mult_i ? LBM : LB1; end
    endcase
  end

  always_comb begin
    reload   = start_i | (retrig_i & on_i);
    step     = tick_i & on_i & timed_q;
    expire_o = step & (cnt_q == ONE) & !reload;
    cnt_d    = cnt_q;
    timed_d  = timed_q;
    if (reload) begin
      cnt_d   = load_val;
      timed_d = sel_timed;
    end else if (step && cnt_q > ONE) begin
      cnt_d   = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      timed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      timed_q <= timed_d;
    end
  end

  // R2: turning on always starts from the full delay
  p_reload_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_i) |-> (cnt_q == $past(load_val)));
  // R2: a timed on-state never holds an empty countdown
  p_timed_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (on_i && timed_q) |-> (cnt_q != '0));
endmodule

// File: rtl/toggle_autooff.sv
module toggle_autooff #(
  parameter int unsigned CLK_PER_TICK    = 100000,
  parameter int unsigned DLY_SHORT_TICKS = 90000,
  parameter int unsigned DLY_LONG_TICKS  = 360000,
  parameter int unsigned MULT_HI         = 24,
  parameter int unsigned PULSE_SHORT_MIN = 5,
  parameter int unsigned PULSE_SHORT_MAX = 12,
  parameter int unsigned PULSE_LONG_MIN  = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       touch_i,
  input  logic [1:0] dly_sel_i,
  input  logic       pol_i,
  input  logic       mult_sel_i,
  input  logic       ovr_i,
  output logic       pin_o,
  output logic       burst_inh_o,
  output logic       recal_req_o
);
  logic tick, held, cancel, retrig, expire, start;
  logic on_q, on_d, armed_q, armed_d, mult_q, mult_d;
  logic touch_ok;

  tao_prescaler #(.DIV(CLK_PER_TICK)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  tao_override_dec #(
    .SHORT_MIN(PULSE_SHORT_MIN), .SHORT_MAX(PULSE_SHORT_MAX), .LONG_MIN(PULSE_LONG_MIN)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .line_i(ovr_i), .idle_lvl_i(mult_q),
    .held_o(held), .cancel_o(cancel), .retrig_o(retrig), .recal_o(recal_req_o)
  );

  tao_offtimer #(
    .DLY_A(DLY_SHORT_TICKS), .DLY_B(DLY_LONG_TICKS), .MULT_HI(MULT_HI)
  ) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(start), .retrig_i(retrig),
    .on_i(on_q), .dly_sel_i(dly_sel_i), .pol_i(pol_i), .mult_i(mult_q),
    .expire_o(expire)
  );

  always_comb begin
    armed_d  = armed_q;
    mult_d   = mult_q;
    if (!armed_q) begin
      armed_d = 1'b1;
      mult_d  = mult_sel_i;
    end
    touch_ok = touch_i & !held;
    start    = touch_ok & !on_q & !cancel;
    if (cancel)        on_d = 1'b0;
    else if (touch_ok) on_d = !on_q;
    else if (expire)   on_d = 1'b0;
    else               on_d = on_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q    <= 1'b0;
      armed_q <= 1'b0;
      mult_q  <= 1'b0;
    end else begin
      on_q    <= on_d;
      armed_q <= armed_d;
      mult_q  <= mult_d;
    end
  end

  assign pin_o       = on_q ^ pol_i;
  assign burst_inh_o = held;

  // R8: a cancel leaves the state off
  p_cancel_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> !on_q);
  // R8: touches during a hold change nothing outside a tick
  p_touch_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (held && touch_i && !tick) |=> $stable(on_q));
  // R4: the captured multiplier never moves once armed
  p_mult_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> $stable(mult_q));
endmodule

// File: tb/sim_toggle_autooff.sv
module sim_toggle_autooff;
  localparam int DIV = 4, DA = 8, DB = 12, MH = 24, SMIN = 2, SMAX = 3, LMIN = 6;

  logic clk = 1'b0, rst_n = 1'b0, touch = 1'b0, pol = 1'b0, mult = 1'b0, ovr = 1'b0;
  logic [1:0] sel = 2'd0;
  logic pin, inh, recal;
  int unsigned e = 0, nvec = 0, nbad = 0;

  always #5 clk = ~clk;

  toggle_autooff #(
    .CLK_PER_TICK(DIV), .DLY_SHORT_TICKS(DA), .DLY_LONG_TICKS(DB), .MULT_HI(MH),
    .PULSE_SHORT_MIN(SMIN), .PULSE_SHORT_MAX(SMAX), .PULSE_LONG_MIN(LMIN)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .touch_i(touch), .dly_sel_i(sel), .pol_i(pol),
    .mult_sel_i(mult), .ovr_i(ovr), .pin_o(pin), .burst_inh_o(inh), .recal_req_o(recal)
  );

  task automatic chk(string req, logic act, logic exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc1();
    @(posedge clk);
    e++;
    @(negedge clk);
  endtask

  task automatic wait_ticks(int k);
    int n = 0;
    while (n < k) begin
      if (e % DIV == DIV - 1) n++;
      cyc1();
    end
  endtask

  task automatic do_touch();
    if (e % DIV == DIV - 1) cyc1();
    touch = 1'b1;
    cyc1();
    touch = 1'b0;
  endtask

  task automatic do_reset(logic p, logic [1:0] c, logic m);
    rst_n = 1'b0; pol = p; sel = c; mult = m; ovr = m; touch = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    e = 0;
  endtask

  function automatic int delay_ticks(logic p, logic [1:0] c, logic m);
    int base;
    if (c >= 2)              base = DB;
    else if ((c == 0) != p)  base = DA;
    else                     base = 0;
    return m ? base * MH : base;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int n;
    // polarity x code x multiplier sweep
    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 4; c++)
        for (int m = 0; m < 2; m++) begin
          do_reset(p[0], c[1:0], m[0]);
          chk("R1 R5 reset off level", pin, p[0]);
          cyc1();
          mult = ~m[0];            // R4: late change must be ignored
          n = delay_ticks(p[0], c[1:0], m[0]);
          do_touch();
          chk("R1 R5 touch turns on", pin, ~p[0]);
          if (n > 0) begin
            wait_ticks(n - 1);
            chk("R2 R3 R4 R6 on before expiry", pin, ~p[0]);
            wait_ticks(1);
            chk("R2 R3 R4 R6 off at expiry", pin, p[0]);
            do_touch();
            chk("R2 second turn-on", pin, ~p[0]);
            wait_ticks(n - 1);
            chk("R2 full delay reloaded", pin, ~p[0]);
            wait_ticks(1);
            chk("R2 second expiry", pin, p[0]);
          end else begin
            wait_ticks(300);
            chk("R3 no timeout stays on", pin, ~p[0]);
            do_touch();
            chk("R1 touch turns off", pin, p[0]);
          end
        end

    // override pulse width sweep, active-high, short delay
    for (int m = 0; m < 2; m++) begin
      do_reset(1'b0, 2'd0, m[0]);
      cyc1();
      n = m ? DA * MH : DA;
      for (int w = 1; w <= 7; w++) begin
        logic cxl, rtg;
        int rem;
        cxl = (w >= LMIN);
        rtg = (w >= SMIN) && (w <= SMAX);
        do_touch();
        chk("R1 on before pulse", pin, 1'b1);
        wait_ticks(1);
        ovr = ~m[0];
        chk("R6 no inhibit before sample", inh, 1'b0);
        wait_ticks(1);
        chk("R6 inhibit at first active sample", inh, 1'b1);
        if (w > 1) wait_ticks(w - 1);
        chk("R7 R8 state during hold", pin, ~cxl);
        do_touch();
        chk("R8 touch ignored during hold", pin, ~cxl);
        chk("R6 inhibit still held", inh, 1'b1);
        ovr = m[0];
        wait_ticks(1);
        chk("R9 recal request at release", recal, 1'b1);
        chk("R6 inhibit released", inh, 1'b0);
        chk("R9 state kept at release", pin, ~cxl);
        cyc1();
        chk("R9 recal lasts one cycle", recal, 1'b0);
        if (cxl) begin
          do_touch();
          chk("R8 touch works after release", pin, 1'b1);
          do_touch();
          chk("R1 touch off after cancel test", pin, 1'b0);
        end else begin
          rem = rtg ? n : n - (w + 2);
          if (rem > 1) wait_ticks(rem - 1);
          chk("R7 on until expected expiry", pin, 1'b1);
          wait_ticks(1);
          chk("R7 off at expected expiry", pin, 1'b0);
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule